// File: doc/BRIEF.md
# Sliding-Window MAP Schedule Controller

This block sequences a sliding-window max-log-MAP soft-in soft-out decoder whose branch-metric storage holds exactly three windows. Time is divided into slots. Each slot is one window of trellis stages long, one stage per clock. In every slot the controller drives up to four concurrent activities:

- generation of branch metrics for a new window;
- forward recursion over an older window;
- a dummy backward recursion that warms up the backward metrics;
- the actual backward recursion, which emits the a-posteriori LLRs.

Branch-metric storage rotates over three buffers. The controller supplies each activity with its buffer select and its stage address. It also drives the write and read addresses of the single-window forward-metric memory.

After a start pulse the controller latches the block length. It then runs W+3 slots, where W is the number of windows, and pulses done once the last LLR has been issued. The datapath (metric arithmetic and memories) sits outside this block. It is connected to these selects, addresses and enables.

Top module: `swmap_sched`

## Requirements
- R1: While idle (after reset, or after a block has finished), every activity enable, done_o and busy_o are low.
- R2: A start pulse is accepted only while idle. The window count is W = blk_len_i / WIN_LEN, and the low log2(WIN_LEN) bits of the length are ignored. A start is ignored when W is 0, when W exceeds MAX_BLK_LEN/WIN_LEN, or when it arrives while busy. The first slot (slot 1, cycle 0) starts on the clock after an accepted start.
- R3: In slot s with s ≤ W, gen_en_o is high for all WIN_LEN cycles. gen_buf_o is (s−1) mod 3, and gen_stage_o counts down from s·WIN_LEN−1 to (s−1)·WIN_LEN, one stage per cycle.
- R4: In slots 3 to W+2, fwd_en_o is high and the forward recursion serves window s−2. fwd_buf_o is s mod 3 and fwd_addr_o counts up from 0 to WIN_LEN−1. fwd_init_o is high only in cycle 0 of slot 3.
- R5: The forward-metric memory address alternates per window. For an odd window w, the address of stage j is j; for an even window, it is WIN_LEN−1−j. fm_waddr_o uses the forward stage. fm_raddr_o uses the backward stage. When both are active in a cycle, the two addresses are equal.
- R6: In slots 3 to W+1, dum_en_o is high and the dummy recursion reads the buffer of window s−1 (dum_buf_o = (s−2) mod 3). dum_addr_o counts down from WIN_LEN−1 to 0. dum_load_o is high in cycle 0 of each such slot only.
- R7: In slot W+2 the window that follows does not exist. dum_en_o stays low there, and dum_term_o is high in cycle 0 only. dum_term_o is never high at any other time.
- R8: In slots 4 to W+3, bwd_en_o is high for window s−3, and bwd_buf_o = (s−1) mod 3, the same buffer that generation writes in that slot. bwd_addr_o counts down from WIN_LEN−1 to 0, and bwd_load_o is high in cycle 0. llr_idx_o equals (s−4)·WIN_LEN + bwd_addr_o.
- R9: done_o is a single-cycle pulse on the cycle after the final LLR (index (W−1)·WIN_LEN). busy_o falls in that same cycle, so a block occupies exactly (W+3)·WIN_LEN busy cycles.
- R10: In any cycle, the buffers used by generation, forward recursion and dummy recursion are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a new block |
| blk_len_i | input | LEN_W | Block length in trellis stages, sampled on an accepted start |
| busy_o | output | 1 | A block is being scheduled |
| gen_en_o | output | 1 | Branch-metric generation active |
| gen_buf_o | output | 2 | Buffer written by generation |
| gen_stage_o | output | LEN_W | Block stage index to generate and store |
| fwd_en_o | output | 1 | Forward recursion active |
| fwd_buf_o | output | 2 | Buffer read by forward recursion |
| fwd_addr_o | output | AW | Stage within window for forward recursion |
| fwd_init_o | output | 1 | Load the starting forward metrics |
| fm_waddr_o | output | AW | Forward-metric memory write address |
| dum_en_o | output | 1 | Dummy backward recursion active |
| dum_buf_o | output | 2 | Buffer read by dummy recursion |
| dum_addr_o | output | AW | Stage within window for dummy recursion |
| dum_load_o | output | 1 | Load the backward start estimate |
| dum_term_o | output | 1 | Load terminated-trellis initial metrics |
| bwd_en_o | output | 1 | Backward recursion and LLR output active |
| bwd_buf_o | output | 2 | Buffer read by backward recursion |
| bwd_addr_o | output | AW | Stage within window for backward recursion |
| bwd_load_o | output | 1 | Take the dummy result as backward start |
| fm_raddr_o | output | AW | Forward-metric memory read address |
| llr_idx_o | output | LEN_W | Block index of the LLR produced this cycle |
| done_o | output | 1 | One-cycle pulse after the final LLR |

## Verification
The assertions check, on every cycle, the relations between concurrent activities:

- the three buffers in use are distinct;
- backward recursion and generation share one buffer and one stage address;
- the forward-metric write and read addresses coincide when both are active;
- the forward address steps up by one;
- termination never coincides with a dummy load or a buffer read;
- done follows the LLR of stage 0.

Only the bench scenarios can show the absolute slot placement of each activity and the exact LLR indices. The same holds for the handling of short, oversized and mid-run starts, and for the total length of a block. These are compared cycle by cycle against a slot model for many block lengths.

// File: rtl/swmap_pkg.sv
package swmap_pkg;

   typedef logic [1:0] bsel_t;

   // advance a three-way buffer select: 0 -> 1 -> 2 -> 0
   function automatic bsel_t bsel_step(input bsel_t b);
      return (b == 2'd2) ? 2'd0 : b + 2'd1;
   endfunction

   // step a three-way buffer select backwards
   function automatic bsel_t bsel_back(input bsel_t b);
      return (b == 2'd0) ? 2'd2 : b - 2'd1;
   endfunction

endpackage

// File: rtl/swmap_slot_timer.sv
module swmap_slot_timer #(
   parameter int WIN_LEN = 32,
   parameter int WIN_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [WIN_W-1:0]           win_i,
   output logic                       busy_o,
   output logic [WIN_W-1:0]           slot_o,
   output logic [$clog2(WIN_LEN)-1:0] cyc_o,
   output logic [WIN_W-1:0]           win_o,
   output logic                       adv_o,
   output logic                       done_o
);
   localparam int AW = $clog2(WIN_LEN);
   localparam logic [AW-1:0] CYC_LAST = AW'(WIN_LEN - 1);

   logic             busy_q;
   logic             done_q;
   logic [WIN_W-1:0] slot_q;
   logic [WIN_W-1:0] win_q;
   logic [AW-1:0]    cyc_q;
   logic [WIN_W-1:0] last_slot;
   logic             slot_end;

   assign last_slot = win_q + WIN_W'(3);
   assign slot_end  = busy_q && (cyc_q == CYC_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         slot_q <= '0;
         win_q  <= '0;
         cyc_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (load_i) begin
               busy_q <= 1'b1;
               slot_q <= WIN_W'(1);
               cyc_q  <= '0;
               win_q  <= win_i;
            end
         end else begin
            cyc_q <= cyc_q + AW'(1);
            if (slot_end) begin
               if (slot_q == last_slot) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  slot_q <= slot_q + WIN_W'(1);
               end
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign slot_o = slot_q;
   assign cyc_o  = cyc_q;
   assign win_o  = win_q;
   assign adv_o  = slot_end && (slot_q != last_slot);
   assign done_o = done_q;

endmodule

// File: rtl/swmap_buf_rotor.sv
module swmap_buf_rotor
   import swmap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  logic  adv_i,
   output bsel_t gsel_o,
   output logic  odd_o
);
   bsel_t gsel_q;
   logic  odd_q;

   // gsel_q tracks (slot-1) mod 3, odd_q tracks slot parity
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gsel_q <= 2'd0;
         odd_q  <= 1'b1;
      end else if (load_i) begin
         gsel_q <= 2'd0;
         odd_q  <= 1'b1;
      end else if (adv_i) begin
         gsel_q <= bsel_step(gsel_q);
         odd_q  <= ~odd_q;
      end
   end

   assign gsel_o = gsel_q;
   assign odd_o  = odd_q;

endmodule

// File: rtl/swmap_phase_dec.sv
module swmap_phase_dec
   import swmap_pkg::*;
#(
   parameter int WIN_LEN = 32,
   parameter int WIN_W   = 8,
   parameter int LEN_W   = 13,
   parameter bit FM_ALT  = 1'b1
) (
   input  logic                       busy_i,
   input  logic [WIN_W-1:0]           slot_i,
   input  logic [$clog2(WIN_LEN)-1:0] cyc_i,
   input  logic [WIN_W-1:0]           win_i,
   input  bsel_t                      gsel_i,
   input  logic                       odd_i,
   output logic                       gen_en_o,
   output bsel_t                      gen_buf_o,
   output logic [LEN_W-1:0]           gen_stage_o,
   output logic                       fwd_en_o,
   output bsel_t                      fwd_buf_o,
   output logic [$clog2(WIN_LEN)-1:0] fwd_addr_o,
   output logic                       fwd_init_o,
   output logic [$clog2(WIN_LEN)-1:0] fm_waddr_o,
   output logic                       dum_en_o,
   output bsel_t                      dum_buf_o,
   output logic [$clog2(WIN_LEN)-1:0] dum_addr_o,
   output logic                       dum_load_o,
   output logic                       dum_term_o,
   output logic                       bwd_en_o,
   output bsel_t                      bwd_buf_o,
   output logic [$clog2(WIN_LEN)-1:0] bwd_addr_o,
   output logic                       bwd_load_o,
   output logic [$clog2(WIN_LEN)-1:0] fm_raddr_o,
   output logic [LEN_W-1:0]           llr_idx_o
);
   localparam int AW    = $clog2(WIN_LEN);
   localparam int IDX_W = WIN_W + AW;

   logic [WIN_W-1:0] w_p1, w_p2;
   logic             gen_act, fwd_act, dum_act, bwd_act, first;
   logic [AW-1:0]    rev;
   logic [IDX_W-1:0] gen_idx, llr_idx;

   assign w_p1  = win_i + WIN_W'(1);
   assign w_p2  = win_i + WIN_W'(2);
   assign first = (cyc_i == '0);
   assign rev   = ~cyc_i;

   // slot windows of the four activities
   assign gen_act = busy_i && (slot_i <= win_i);
   assign fwd_act = busy_i && (slot_i >= WIN_W'(3)) && (slot_i <= w_p2);
   assign dum_act = busy_i && (slot_i >= WIN_W'(3)) && (slot_i <= w_p1);
   assign bwd_act = busy_i && (slot_i >= WIN_W'(4));

   assign gen_idx = {slot_i - WIN_W'(1), rev};
   assign llr_idx = {slot_i - WIN_W'(4), rev};

   // generation
   assign gen_en_o    = gen_act;
   assign gen_buf_o   = gsel_i;
   assign gen_stage_o = gen_act ? gen_idx[LEN_W-1:0] : '0;

   // forward recursion, window slot-2
   assign fwd_en_o   = fwd_act;
   assign fwd_buf_o  = bsel_step(gsel_i);
   assign fwd_addr_o = fwd_act ? cyc_i : '0;
   assign fwd_init_o = fwd_act && first && (slot_i == WIN_W'(3));

   // dummy backward recursion over window slot-1
   assign dum_en_o   = dum_act;
   assign dum_buf_o  = bsel_back(gsel_i);
   assign dum_addr_o = dum_act ? rev : '0;
   assign dum_load_o = dum_act && first;
   assign dum_term_o = busy_i && first && (slot_i == w_p2);

   // backward recursion and LLR output, window slot-3
   assign bwd_en_o   = bwd_act;
   assign bwd_buf_o  = gsel_i;
   assign bwd_addr_o = bwd_act ? rev : '0;
   assign bwd_load_o = bwd_act && first;
   assign llr_idx_o  = bwd_act ? llr_idx[LEN_W-1:0] : '0;

   // forward-metric memory addressing
   generate
      if (FM_ALT) begin : g_fm_alt
         // forward window parity equals slot parity; backward window has the other
         assign fm_waddr_o = !fwd_act ? '0 : (odd_i ? cyc_i : rev);
         assign fm_raddr_o = !bwd_act ? '0 : (odd_i ? cyc_i : rev);
      end else begin : g_fm_plain
         assign fm_waddr_o = fwd_act ? cyc_i : '0;
         assign fm_raddr_o = bwd_act ? rev : '0;
      end
   endgenerate

endmodule

// File: rtl/swmap_sched.sv
module swmap_sched
   import swmap_pkg::*;
#(
   parameter int WIN_LEN     = 32,
   parameter int MAX_BLK_LEN = 6144,
   parameter bit FM_ALT      = 1'b1,
   parameter int LEN_W       = $clog2(MAX_BLK_LEN + 1),
   parameter int AW          = $clog2(WIN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] blk_len_i,
   output logic             busy_o,
   output logic             gen_en_o,
   output logic [1:0]       gen_buf_o,
   output logic [LEN_W-1:0] gen_stage_o,
   output logic             fwd_en_o,
   output logic [1:0]       fwd_buf_o,
   output logic [AW-1:0]    fwd_addr_o,
   output logic             fwd_init_o,
   output logic [AW-1:0]    fm_waddr_o,
   output logic             dum_en_o,
   output logic [1:0]       dum_buf_o,
   output logic [AW-1:0]    dum_addr_o,
   output logic             dum_load_o,
   output logic             dum_term_o,
   output logic             bwd_en_o,
   output logic [1:0]       bwd_buf_o,
   output logic [AW-1:0]    bwd_addr_o,
   output logic             bwd_load_o,
   output logic [AW-1:0]    fm_raddr_o,
   output logic [LEN_W-1:0] llr_idx_o,
   output logic             done_o
);
   localparam int MAX_WIN = MAX_BLK_LEN / WIN_LEN;
   localparam int WIN_W   = $clog2(MAX_WIN + 4);

   generate
      if (WIN_LEN < 2 || (1 << AW) != WIN_LEN) begin : g_bad_win
         $error("WIN_LEN must be a power of two of at least 2");
      end
      if (MAX_BLK_LEN < WIN_LEN) begin : g_bad_blk
         $error("MAX_BLK_LEN must hold at least one window");
      end
      if (LEN_W > WIN_W + AW || AW != $clog2(WIN_LEN)) begin : g_bad_w
         $error("index widths inconsistent with window parameters");
      end
   endgenerate

   logic [LEN_W-1:0] win_full;
   logic             win_ok, accept, busy, adv;
   logic [WIN_W-1:0] win_req, slot, win_q;
   logic [AW-1:0]    cyc;
   bsel_t            gsel;
   logic             odd;

   assign win_full = blk_len_i >> AW;
   assign win_ok   = (win_full != '0) && (win_full <= LEN_W'(MAX_WIN));
   assign win_req  = WIN_W'(win_full);
   assign accept   = start_i && !busy && win_ok;

   swmap_slot_timer #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .win_i(win_req),
      .busy_o(busy), .slot_o(slot), .cyc_o(cyc), .win_o(win_q),
      .adv_o(adv), .done_o(done_o)
   );

   swmap_buf_rotor u_rotor (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .adv_i(adv),
      .gsel_o(gsel), .odd_o(odd)
   );

   swmap_phase_dec #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W), .LEN_W(LEN_W), .FM_ALT(FM_ALT)) u_dec (
      .busy_i(busy), .slot_i(slot), .cyc_i(cyc), .win_i(win_q),
      .gsel_i(gsel), .odd_i(odd),
      .gen_en_o(gen_en_o), .gen_buf_o(gen_buf_o), .gen_stage_o(gen_stage_o),
      .fwd_en_o(fwd_en_o), .fwd_buf_o(fwd_buf_o), .fwd_addr_o(fwd_addr_o),
      .fwd_init_o(fwd_init_o), .fm_waddr_o(fm_waddr_o),
      .dum_en_o(dum_en_o), .dum_buf_o(dum_buf_o), .dum_addr_o(dum_addr_o),
      .dum_load_o(dum_load_o), .dum_term_o(dum_term_o),
      .bwd_en_o(bwd_en_o), .bwd_buf_o(bwd_buf_o), .bwd_addr_o(bwd_addr_o),
      .bwd_load_o(bwd_load_o), .fm_raddr_o(fm_raddr_o), .llr_idx_o(llr_idx_o)
   );

   assign busy_o = busy;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !gen_en_o && !fwd_en_o && !dum_en_o && !bwd_en_o && !dum_term_o); // R1
   AST_GEN_FWD_APART: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en_o && fwd_en_o |-> gen_buf_o != fwd_buf_o); // R10
   AST_FWD_DUM_APART: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_en_o && dum_en_o |-> fwd_buf_o != dum_buf_o); // R10
   AST_GEN_DUM_APART: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en_o && dum_en_o |-> gen_buf_o != dum_buf_o); // R10
   AST_BWD_ON_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en_o && bwd_en_o |-> gen_buf_o == bwd_buf_o && gen_stage_o[AW-1:0] == bwd_addr_o); // R8
   AST_FM_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_en_o && bwd_en_o && FM_ALT |-> fm_waddr_o == fm_raddr_o); // R5
   AST_FWD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_en_o && $past(fwd_en_o) && fwd_addr_o != '0 |-> fwd_addr_o == $past(fwd_addr_o) + AW'(1)); // R4
   AST_TERM_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      dum_term_o |-> !dum_en_o && !dum_load_o); // R7
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(bwd_en_o) && $past(bwd_addr_o) == '0 && !busy_o); // R9

endmodule

// File: tb/swmap_sched_bench.sv
module swmap_sched_bench;
   localparam int M     = 32;
   localparam int MAXB  = 6144;
   localparam int LW    = $clog2(MAXB + 1);
   localparam int AWB   = $clog2(M);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [LW-1:0] blk_len_i = '0;
   logic busy_o, gen_en_o, fwd_en_o, fwd_init_o, dum_en_o, dum_load_o, dum_term_o;
   logic bwd_en_o, bwd_load_o, done_o;
   logic [1:0] gen_buf_o, fwd_buf_o, dum_buf_o, bwd_buf_o;
   logic [LW-1:0] gen_stage_o, llr_idx_o;
   logic [AWB-1:0] fwd_addr_o, fm_waddr_o, dum_addr_o, bwd_addr_o, fm_raddr_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   swmap_sched #(.WIN_LEN(M), .MAX_BLK_LEN(MAXB)) u_swmap_sched (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_len_i(blk_len_i),
      .busy_o(busy_o), .gen_en_o(gen_en_o), .gen_buf_o(gen_buf_o), .gen_stage_o(gen_stage_o),
      .fwd_en_o(fwd_en_o), .fwd_buf_o(fwd_buf_o), .fwd_addr_o(fwd_addr_o),
      .fwd_init_o(fwd_init_o), .fm_waddr_o(fm_waddr_o),
      .dum_en_o(dum_en_o), .dum_buf_o(dum_buf_o), .dum_addr_o(dum_addr_o),
      .dum_load_o(dum_load_o), .dum_term_o(dum_term_o),
      .bwd_en_o(bwd_en_o), .bwd_buf_o(bwd_buf_o), .bwd_addr_o(bwd_addr_o),
      .bwd_load_o(bwd_load_o), .fm_raddr_o(fm_raddr_o), .llr_idx_o(llr_idx_o),
      .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_v(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   // forward-metric memory address of stage j in window w
   function automatic int fm_addr(input int w, input int j);
      return (w % 2 == 1) ? j : M - 1 - j;
   endfunction

   task automatic chk_idle(input string req);
      chk_v({req, " busy"}, int'(busy_o), 0);
      chk_v({req, " enables"}, int'({gen_en_o, fwd_en_o, dum_en_o, bwd_en_o, dum_term_o}), 0);
      chk_v({req, " done"}, int'(done_o), 0);
   endtask

   // run one block; inj_t >= 0 drives an extra start at that cycle offset
   task automatic run_block(input int len, input int inj_t, input int inj_len);
      int w;
      int t_end;
      w = len / M;
      @(negedge clk);
      blk_len_i = LW'(len);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      blk_len_i = '0;
      t_end = (w + 3) * M;
      for (int t = 0; t < t_end; t++) begin
         int s, c;
         bit eg, ef, ed, eb;
         s = t / M + 1;
         c = t % M;
         eg = (s <= w);
         ef = (s >= 3) && (s <= w + 2);
         ed = (s >= 3) && (s <= w + 1);
         eb = (s >= 4);
         chk_v("R2 busy", int'(busy_o), 1);
         chk_v("R9 done early", int'(done_o), 0);
         chk_v("R3 gen_en", int'(gen_en_o), int'(eg));
         if (eg) begin
            chk_v("R3 gen_buf", int'(gen_buf_o), (s - 1) % 3);
            chk_v("R3 gen_stage", int'(gen_stage_o), (s - 1) * M + M - 1 - c);
         end
         chk_v("R4 fwd_en", int'(fwd_en_o), int'(ef));
         chk_v("R4 fwd_init", int'(fwd_init_o), int'(s == 3 && c == 0));
         if (ef) begin
            chk_v("R4 fwd_buf", int'(fwd_buf_o), s % 3);
            chk_v("R4 fwd_addr", int'(fwd_addr_o), c);
            chk_v("R5 fm_waddr", int'(fm_waddr_o), fm_addr(s - 2, c));
         end
         chk_v("R6 dum_en", int'(dum_en_o), int'(ed));
         chk_v("R6 dum_load", int'(dum_load_o), int'(ed && c == 0));
         chk_v("R7 dum_term", int'(dum_term_o), int'(s == w + 2 && c == 0));
         if (ed) begin
            chk_v("R6 dum_buf", int'(dum_buf_o), (s - 2) % 3);
            chk_v("R6 dum_addr", int'(dum_addr_o), M - 1 - c);
         end
         chk_v("R8 bwd_en", int'(bwd_en_o), int'(eb));
         chk_v("R8 bwd_load", int'(bwd_load_o), int'(eb && c == 0));
         if (eb) begin
            chk_v("R8 bwd_buf", int'(bwd_buf_o), (s - 1) % 3);
            chk_v("R8 bwd_addr", int'(bwd_addr_o), M - 1 - c);
            chk_v("R8 llr_idx", int'(llr_idx_o), (s - 4) * M + M - 1 - c);
            chk_v("R5 fm_raddr", int'(fm_raddr_o), fm_addr(s - 3, M - 1 - c));
         end
         if (eg) begin
            chk_v("R10 gen/fwd/dum distinct", int'((ef && gen_buf_o == fwd_buf_o) ||
                  (ed && gen_buf_o == dum_buf_o) || (ef && ed && fwd_buf_o == dum_buf_o)), 0);
         end
         if (t == inj_t) begin
            blk_len_i = LW'(inj_len);
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      chk_v("R9 done pulse", int'(done_o), 1);
      chk_v("R9 busy falls", int'(busy_o), 0);
      chk_v("R9 no llr", int'(bwd_en_o), 0);
      @(negedge clk);
      chk_v("R9 done single", int'(done_o), 0);
      chk_idle("R1 after block");
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after reset");

      // R2: ignored starts (zero windows, too many windows)
      blk_len_i = LW'(M - 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk_v("R2 zero windows ignored", int'(busy_o), 0);
      blk_len_i = LW'((MAXB / M + 1) * M);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk_v("R2 oversize ignored", int'(busy_o), 0);

      // directed corners
      run_block(M, -1, 0);                 // single window, termination at slot 3
      run_block(2 * M, 5, 7 * M);          // start while busy ignored
      run_block(3 * M + 17, -1, 0);        // low bits ignored
      run_block(4 * M, 3 * M + 2, M);      // mid-run start with other length
      run_block(MAXB, -1, 0);              // longest block

      // random lengths
      for (int i = 0; i < 8; i++) begin
         int wr, lo, inj;
         wr = 1 + int'($urandom % 24);
         lo = int'($urandom % M);
         inj = ($urandom % 2 == 0) ? int'($urandom % ((wr + 3) * M)) : -1;
         run_block(wr * M + lo, inj, 1 + int'($urandom % 4) * M);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule